// File: doc/BRIEF.md
# Block-Prefetch Instruction Buffer Controller

This block is the instruction buffer that sits in front of an instruction decoder. The buffer keeps a small number of instruction blocks. Each block is eight 64-bit words, and each word packs two 32-bit instructions, so one block carries sixteen instructions. The block tracks a program counter counted in instruction units and hands the decoder one instruction per cycle with a valid/ready pair. A jump input loads a new program counter. When the block that holds the program counter is absent, the valid output drops and the block stays stalled until memory returns that block.

Fetching is driven by position within the current block. Once the program counter reaches the second half of its block, the controller looks up the following block. If that block is absent, the controller asks memory for it, and it makes this decision without regard to any jump that might come later. A jump target goes through the same lookup. The memory side takes one request at a time. Each request is a single-cycle pulse that carries a block address. The response is a single-cycle pulse that carries the whole 512-bit block. Each arriving block is written into the slot named by a rotating pointer, which always points at the block that was filled longest ago.

The fetch state machine has three states. FS_IDLE waits for a need and moves to FS_ISSUE when the current block is absent, or when the program counter is in the second half and the next block is absent. FS_ISSUE drives the request for one cycle and always moves to FS_WAIT. FS_WAIT holds until the response pulse, writes the block, advances the pointer and returns to FS_IDLE.

Top module: `ibuf_ctrl`

## Requirements
- R1: During reset and in the reset state, instr_valid is 0, mem_req_valid is 0, instr_pc is 0 and every slot is empty. The first request after reset is for block 0.
- R2: The instruction at program counter p is bits [32*(p mod 16) +: 32] of the 512-bit line of block p/16. In other words, word (p mod 16)/2 holds it, even p in the low half and odd p in the high half. Each cycle with instr_valid and instr_ready both 1 and no jump advances instr_pc by one.
- R3: instr_valid is 1 exactly when the block of instr_pc is resident. While instr_valid is 0 and no jump is applied, instr_pc holds its value.
- R4: When the block is idle, the current block is resident, the offset (instr_pc mod 16) is 8 or more and block instr_pc/16+1 is absent, the next block is requested. The request appears on the cycle after the one in which offset 8 is first reached. No prefetch is made for offsets 0 to 7.
- R5: No request is ever made for a block that is already resident.
- R6: Arriving blocks fill slots 0,1,2,3,0,... in order. The fifth distinct block evicts the first one filled, and a block is never held in two slots.
- R7: jump_valid loads jump_target into instr_pc on the next cycle, overriding any advance. The target block then goes through the same lookup and fetch as R3 and R4.
- R8: At most one request is outstanding. A miss caused by a jump while a prefetch is in flight is requested only after that prefetch's response.
- R9: In straight-line code with instr_ready held at 1 and a memory response three cycles after the request is sampled, instr_valid never drops after the first instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| jump_valid | input | 1 | Load jump_target as the new program counter |
| jump_target | input | PC_W | Jump destination in instruction units |
| instr_ready | input | 1 | Decoder accepts the presented instruction |
| instr_valid | output | 1 | Presented instruction is valid |
| instr_pc | output | PC_W | Program counter of the presented instruction |
| instr_data | output | INSTR_W | Presented instruction |
| mem_req_valid | output | 1 | Single-cycle block request |
| mem_req_blk | output | PC_W-4 | Requested block address |
| mem_rsp_valid | input | 1 | Single-cycle block response |
| mem_rsp_data | input | 512 | Whole block; instruction i at bits [32*i +: 32] |

## Verification
The first pattern is a straight-line run from reset with the decoder always ready. It shows where prefetch triggers: the request must come exactly at offset 9, so a trigger one instruction early or late is caught. It also shows whether the three-cycle latency stays hidden. A series of jumps into resident, evicted and never-filled blocks then separates correct cyclic replacement from any other victim order, and a suppressed fetch from a redundant one. A last pattern uses a slow memory. It parks the counter at offset 6 to show that no early prefetch occurs, then steps the counter to offset 8 and jumps away while that prefetch is in flight, which tests the one-request limit. Throughout the run, every presented instruction and every valid level is compared with a residency model kept in the bench.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ISSUE = 2'd1,
        FS_WAIT  = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/ibuf_tags.sv
module ibuf_tags #(
    parameter int NBLK  = 4,
    parameter int BLK_W = 12,
    parameter int NLOOK = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NBLK)-1:0]     wr_slot,
    input  logic [BLK_W-1:0]            wr_blk,
    input  logic [NLOOK-1:0][BLK_W-1:0] look_blk,
    output logic [NLOOK-1:0]            look_hit,
    output logic [$clog2(NBLK)-1:0]     rd_slot
);

    localparam int SLOT_W = $clog2(NBLK);

    logic [BLK_W-1:0]             tag_q [NBLK];
    logic [NBLK-1:0]              valid_q;
    logic [NLOOK-1:0][NBLK-1:0]   match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_slot] <= wr_blk;
        end
    end

    genvar gl, gs;
    generate
        for (gl = 0; gl < NLOOK; gl++) begin : g_look
            for (gs = 0; gs < NBLK; gs++) begin : g_slot
                assign match[gl][gs] = valid_q[gs] && (tag_q[gs] == look_blk[gl]);
            end
            assign look_hit[gl] = |match[gl];

            // R6: a block never occupies two slots
            a_r6_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(match[gl]));
        end
    endgenerate

    always_comb begin
        rd_slot = '0;
        for (int s = 0; s < NBLK; s++) begin
            if (match[0][s]) begin
                rd_slot = SLOT_W'(s);
            end
        end
    end

endmodule

// File: rtl/ibuf_lines.sv
module ibuf_lines #(
    parameter int NBLK    = 4,
    parameter int WORDS   = 8,
    parameter int INSTR_W = 32
) (
    input  logic                            clk,
    input  logic                            wr_en,
    input  logic [$clog2(NBLK)-1:0]         wr_slot,
    input  logic [WORDS*2*INSTR_W-1:0]      wr_line,
    input  logic [$clog2(NBLK)-1:0]         rd_slot,
    input  logic [$clog2(2*WORDS)-1:0]      rd_off,
    output logic [INSTR_W-1:0]              rd_instr
);

    localparam int WORD_W = 2 * INSTR_W;
    localparam int LINE_W = WORDS * WORD_W;
    localparam int OFF_W  = $clog2(2 * WORDS);

    logic [LINE_W-1:0] line_q [NBLK];
    logic [LINE_W-1:0] sel_line;
    logic [WORD_W-1:0] words [WORDS];
    logic [WORD_W-1:0] sel_word;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_slot] <= wr_line;
        end
    end

    assign sel_line = line_q[rd_slot];

    genvar gw;
    generate
        for (gw = 0; gw < WORDS; gw++) begin : g_word
            assign words[gw] = sel_line[gw*WORD_W +: WORD_W];
        end
    endgenerate

    assign sel_word = words[rd_off[OFF_W-1:1]];
    assign rd_instr = rd_off[0] ? sel_word[WORD_W-1:INSTR_W] : sel_word[INSTR_W-1:0];

endmodule

// File: rtl/ibuf_fetch.sv
module ibuf_fetch
    import ibuf_pkg::*;
#(
    parameter int NBLK  = 4,
    parameter int BLK_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BLK_W-1:0]        cur_blk,
    input  logic [BLK_W-1:0]        nxt_blk,
    input  logic                    cur_hit,
    input  logic                    nxt_hit,
    input  logic                    second_half,
    input  logic                    rsp_valid,
    output logic                    req_valid,
    output logic [BLK_W-1:0]        req_blk,
    output logic                    fill_en,
    output logic [$clog2(NBLK)-1:0] fill_slot
);

    localparam int SLOT_W = $clog2(NBLK);

    fetch_state_e        state_q, state_d;
    logic [BLK_W-1:0]    tgt_q;
    logic [SLOT_W-1:0]   victim_q;
    logic                need;
    logic                pick_cur;

    assign pick_cur = !cur_hit;
    assign need     = !cur_hit || (second_half && !nxt_hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  if (need) state_d = FS_ISSUE;
            FS_ISSUE: state_d = FS_WAIT;
            FS_WAIT:  if (rsp_valid) state_d = FS_IDLE;
            default:  state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q    <= '0;
            victim_q <= '0;
        end else begin
            if (state_q == FS_IDLE && need) begin
                tgt_q <= pick_cur ? cur_blk : nxt_blk;
            end
            if (fill_en) begin
                victim_q <= (victim_q == SLOT_W'(NBLK - 1)) ? '0 : victim_q + 1'b1;
            end
        end
    end

    always_comb begin
        req_valid = (state_q == FS_ISSUE);
        req_blk   = tgt_q;
        fill_en   = (state_q == FS_WAIT) && rsp_valid;
        fill_slot = victim_q;
    end

    // R8: a request lasts exactly one cycle
    a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R4: a request decided while the current block was resident is a second-half prefetch
    a_r4_prefetch_half: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(cur_hit)) |-> $past(second_half));

endmodule

// File: rtl/ibuf_ctrl.sv
module ibuf_ctrl #(
    parameter int PC_W    = 16,
    parameter int NBLK    = 4,
    parameter int WORDS   = 8,
    parameter int INSTR_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            jump_valid,
    input  logic [PC_W-1:0]                 jump_target,
    input  logic                            instr_ready,
    output logic                            instr_valid,
    output logic [PC_W-1:0]                 instr_pc,
    output logic [INSTR_W-1:0]              instr_data,
    output logic                            mem_req_valid,
    output logic [PC_W-$clog2(2*WORDS)-1:0] mem_req_blk,
    input  logic                            mem_rsp_valid,
    input  logic [WORDS*2*INSTR_W-1:0]      mem_rsp_data
);

    localparam int OFF_W  = $clog2(2 * WORDS);
    localparam int BLK_W  = PC_W - OFF_W;
    localparam int SLOT_W = $clog2(NBLK);
    localparam int NLOOK  = 3;

    logic [PC_W-1:0]             pc_q;
    logic [BLK_W-1:0]            cur_blk;
    logic [BLK_W-1:0]            nxt_blk;
    logic [NLOOK-1:0][BLK_W-1:0] look_blk;
    logic [NLOOK-1:0]            look_hit;
    logic [SLOT_W-1:0]           rd_slot;
    logic                        fill_en;
    logic [SLOT_W-1:0]           fill_slot;

    assign cur_blk  = pc_q[PC_W-1:OFF_W];
    assign nxt_blk  = cur_blk + 1'b1;
    assign look_blk = {mem_req_blk, nxt_blk, cur_blk};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (jump_valid) begin
            pc_q <= jump_target;
        end else if (instr_valid && instr_ready) begin
            pc_q <= pc_q + 1'b1;
        end
    end

    ibuf_tags #(
        .NBLK  (NBLK),
        .BLK_W (BLK_W),
        .NLOOK (NLOOK)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_en),
        .wr_slot  (fill_slot),
        .wr_blk   (mem_req_blk),
        .look_blk (look_blk),
        .look_hit (look_hit),
        .rd_slot  (rd_slot)
    );

    ibuf_lines #(
        .NBLK    (NBLK),
        .WORDS   (WORDS),
        .INSTR_W (INSTR_W)
    ) u_lines (
        .clk      (clk),
        .wr_en    (fill_en),
        .wr_slot  (fill_slot),
        .wr_line  (mem_rsp_data),
        .rd_slot  (rd_slot),
        .rd_off   (pc_q[OFF_W-1:0]),
        .rd_instr (instr_data)
    );

    ibuf_fetch #(
        .NBLK  (NBLK),
        .BLK_W (BLK_W)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_blk     (cur_blk),
        .nxt_blk     (nxt_blk),
        .cur_hit     (look_hit[0]),
        .nxt_hit     (look_hit[1]),
        .second_half (pc_q[OFF_W-1]),
        .rsp_valid   (mem_rsp_valid),
        .req_valid   (mem_req_valid),
        .req_blk     (mem_req_blk),
        .fill_en     (fill_en),
        .fill_slot   (fill_slot)
    );

    assign instr_valid = look_hit[0];
    assign instr_pc    = pc_q;

    logic outst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
        end else if (mem_req_valid) begin
            outst_q <= 1'b1;
        end else if (mem_rsp_valid) begin
            outst_q <= 1'b0;
        end
    end

    // R8: no new request while one is outstanding
    a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && outst_q));

    // R5: the requested block is never already resident
    a_r5_no_resident_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !look_hit[2]);

    // R3: a stalled counter holds
    a_r3_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !jump_valid) |=> $stable(instr_pc));

    // R2: an accepted instruction advances the counter by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && !jump_valid) |=> (instr_pc == $past(instr_pc) + 1'b1));

    // R7: a jump loads its target
    a_r7_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
        jump_valid |=> (instr_pc == $past(jump_target)));

endmodule

// File: tb/tb_ibuf_ctrl.sv
`timescale 1ns/1ps
module tb_ibuf_ctrl;

    localparam int PC_W   = 16;
    localparam int BLK_W  = 12;
    localparam int LINE_W = 512;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              jump_valid = 1'b0;
    logic [PC_W-1:0]   jump_target = '0;
    logic              instr_ready = 1'b0;
    logic              instr_valid;
    logic [PC_W-1:0]   instr_pc;
    logic [31:0]       instr_data;
    logic              mem_req_valid;
    logic [BLK_W-1:0]  mem_req_blk;
    logic              mem_rsp_valid = 1'b0;
    logic [LINE_W-1:0] mem_rsp_data = '0;

    ibuf_ctrl dut (
        .clk(clk), .rst_n(rst_n), .jump_valid(jump_valid), .jump_target(jump_target),
        .instr_ready(instr_ready), .instr_valid(instr_valid), .instr_pc(instr_pc),
        .instr_data(instr_data), .mem_req_valid(mem_req_valid), .mem_req_blk(mem_req_blk),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] instr_of(input logic [PC_W-1:0] p);
        return {p ^ 16'h5A3C, p};
    endfunction

    function automatic logic [LINE_W-1:0] line_of(input logic [BLK_W-1:0] b);
        logic [LINE_W-1:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = instr_of({b, 4'(i)});
        return r;
    endfunction

    // memory and residency model
    int               mem_lat = 3;
    int               cnt = 0;
    bit               busy = 1'b0;
    bit               outst = 1'b0;
    logic [BLK_W-1:0] pend_blk = '0;
    logic [BLK_W-1:0] m_tag [4];
    bit   [3:0]       m_val = '0;
    int               m_ptr = 0;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst_n) begin
            busy <= 1'b0; outst <= 1'b0; m_val <= '0; m_ptr <= 0;
        end else begin
            if (mem_rsp_valid) begin
                m_tag[m_ptr] <= pend_blk;
                m_val[m_ptr] <= 1'b1;
                m_ptr <= (m_ptr + 1) % 4;
                outst <= 1'b0;
            end
            if (mem_req_valid) begin
                pend_blk <= mem_req_blk; cnt <= mem_lat; busy <= 1'b1; outst <= 1'b1;
            end else if (busy) begin
                if (cnt == 1) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= line_of(pend_blk);
                    busy <= 1'b0;
                end else begin
                    cnt <= cnt - 1;
                end
            end
        end
    end

    function automatic bit resident(input logic [BLK_W-1:0] b);
        for (int s = 0; s < 4; s++) if (m_val[s] && m_tag[s] == b) return 1'b1;
        return 1'b0;
    endfunction

    logic [BLK_W-1:0] log_blk [64];
    logic [PC_W-1:0]  log_pc  [64];
    int nlog = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(instr_valid == resident(instr_pc[15:4]), "R3", instr_valid, resident(instr_pc[15:4]));
            if (instr_valid) chk(instr_data == instr_of(instr_pc), "R2", instr_data, instr_of(instr_pc));
            if (mem_req_valid) begin
                chk(!outst, "R8", outst, 0);
                chk(!resident(mem_req_blk), "R5", mem_req_blk, 0);
                if (nlog < 64) begin
                    log_blk[nlog] = mem_req_blk;
                    log_pc[nlog]  = instr_pc;
                    nlog++;
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_jump(input logic [PC_W-1:0] t);
        @(negedge clk);
        jump_valid = 1'b1; jump_target = t;
        @(negedge clk);
        jump_valid = 1'b0;
        chk(instr_pc == t, "R7", instr_pc, t);
    endtask

    initial begin
        #(20 * 50000);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int exp_pc;
        int stalls;
        bit seen;
        bit pre_ok;
        int n0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(instr_valid == 0, "R1", instr_valid, 0);
        chk(mem_req_valid == 0, "R1", mem_req_valid, 0);
        chk(instr_pc == 0, "R1", instr_pc, 0);
        rst_n = 1'b1;

        // straight line run, R2 R3 R4 R9
        exp_pc = 0; stalls = 0; seen = 0; pre_ok = 1;
        instr_ready = 1'b1;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (instr_valid) begin
                seen = 1;
                chk(instr_pc == exp_pc, "R2", instr_pc, exp_pc);
                if (exp_pc == 40) begin
                    instr_ready = 1'b0;
                    break;
                end
                exp_pc++;
            end else if (seen) begin
                stalls++;
            end else if (instr_pc != 0) begin
                pre_ok = 0;
            end
        end
        chk(exp_pc == 40, "R2", exp_pc, 40);
        chk(stalls == 0, "R9", stalls, 0);
        chk(pre_ok, "R3", pre_ok, 1);
        idle(15);
        chk(nlog == 4, "R4", nlog, 4);
        chk(log_blk[0] == 0, "R1", log_blk[0], 0);
        chk(log_pc[0] == 0, "R1", log_pc[0], 0);
        for (int b = 1; b < 4; b++) chk(log_blk[b] == BLK_W'(b), "R4", log_blk[b], b);
        chk(log_pc[1] == 9, "R4", log_pc[1], 9);
        chk(log_pc[2] == 25, "R4", log_pc[2], 25);
        chk(log_pc[3] == 40, "R4", log_pc[3], 40);

        // jumps and replacement, R5 R6 R7
        do_jump(16'd21);
        chk(instr_valid == 1, "R5", instr_valid, 1);
        chk(instr_data == instr_of(16'd21), "R7", instr_data, instr_of(16'd21));
        idle(10);
        chk(nlog == 4, "R5", nlog, 4);

        do_jump(16'd58);
        idle(10);
        chk(nlog == 5, "R4", nlog, 5);
        chk(log_blk[4] == 4, "R4", log_blk[4], 4);

        do_jump(16'd3);
        chk(instr_valid == 0, "R6", instr_valid, 0);
        idle(12);
        chk(nlog == 6, "R6", nlog, 6);
        chk(log_blk[5] == 0, "R6", log_blk[5], 0);
        chk(instr_valid == 1, "R3", instr_valid, 1);

        do_jump(16'd32);
        chk(instr_valid == 1, "R6", instr_valid, 1);
        idle(5);
        chk(nlog == 6, "R5", nlog, 6);

        do_jump(16'd16);
        chk(instr_valid == 0, "R6", instr_valid, 0);
        idle(12);
        chk(nlog == 7, "R6", nlog, 7);
        chk(log_blk[6] == 1, "R6", log_blk[6], 1);

        do_jump(16'd66);
        chk(instr_valid == 1, "R6", instr_valid, 1);

        // slow memory, R4 lower half and R8
        idle(5);
        mem_lat = 10;
        do_jump(16'd102);
        chk(instr_valid == 0, "R3", instr_valid, 0);
        idle(25);
        chk(instr_valid == 1, "R3", instr_valid, 1);
        n0 = nlog;
        chk(log_blk[n0-1] == 6, "R7", log_blk[n0-1], 6);
        idle(10);
        chk(nlog == n0, "R4", nlog, n0);

        instr_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        instr_ready = 1'b0;
        chk(instr_pc == 104, "R2", instr_pc, 104);
        idle(2);
        chk(nlog == n0 + 1, "R4", nlog, n0 + 1);
        chk(log_blk[n0] == 7, "R4", log_blk[n0], 7);
        chk(log_pc[n0] == 104, "R4", log_pc[n0], 104);

        do_jump(16'd320);
        idle(3);
        chk(nlog == n0 + 1, "R8", nlog, n0 + 1);
        idle(30);
        chk(nlog == n0 + 2, "R8", nlog, n0 + 2);
        chk(log_blk[n0+1] == 20, "R8", log_blk[n0+1], 20);
        chk(instr_valid == 1, "R7", instr_valid, 1);
        chk(instr_pc == 320, "R7", instr_pc, 320);
        chk(instr_data == instr_of(16'd320), "R7", instr_data, instr_of(16'd320));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule